// File: doc/BRIEF.md
# Serial Memory Status Register and Write-Protection Guard

This block holds the status byte of a serial non-volatile memory and decides, every cycle, whether a requested write may proceed. It keeps the write-enable latch, the two block-protect bits that fence off the top quarter, the top half or the whole array, and a protect-enable bit that lets an active-low write-protect pin lock the status byte. The command decoder around it sends one-cycle strobes for the enable, disable and status-write commands, plus a strobe when chip select is released. The array path presents the address it is about to program. An external write-cycle timer reports the busy flag.

A status write is captured when its data byte arrives and is only committed when chip select is released. If hardware protection becomes active before then, the pending write is dropped. A committed status write pulses a start output so that the timer can run the same timed internal cycle an array write uses. At the end of any internal cycle, when busy falls, the write-enable latch clears. While busy, the read-back byte is all ones and every command strobe is ignored.

Top module: `sr_protect_ctrl`

## Requirements
- R1: After synchronous reset the read-back byte is 8'h00 (latch clear, protect bits 0, protect-enable 0), and both allow outputs and the start pulse are 0.
- R2: A write-enable strobe sets the latch (read-back bit 1) from the next cycle. A write-disable strobe clears it from the next cycle, whatever the level of the write-protect pin.
- R3: While busy is high, the read-back byte is 8'hFF and enable, disable and status-write strobes have no effect.
- R4: When not busy, the read-back byte is {protect-enable, 3'b000, protect bit 1, protect bit 0, latch, 1'b0}.
- R5: Protect bits {b1,b0} fence addresses as follows: 00 nothing; 01 the top quarter (two address MSBs 11); 10 the top half (address MSB 1); 11 everything. The array-allow output is latch AND not busy AND address not fenced.
- R6: The latch clears in the cycle after busy falls.
- R7: A status write is accepted only if the latch is set, the block is not busy and it is not hardware-locked. It is committed on the chip-select-release strobe. The new protect-enable (data bit 7) and protect bits (data bits 3 and 2) appear from the next cycle, together with a one-cycle start pulse.
- R8: A status-write strobe while the latch is clear leaves the status byte unchanged and produces no start pulse.
- R9: With the pin low and protect-enable 1, the status-allow output is 0 and status writes are refused, so protect-enable cannot be cleared.
- R10: With protect-enable 0, a low write-protect pin does not block status writes.
- R11: If the pin goes low with protect-enable 1 between the data byte and the chip-select release, the pending status write is discarded: no start pulse and no change.
- R12: The write-protect pin has no effect on array-allow for unfenced addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wp_n_i | input | 1 | Write-protect pin, low asserts |
| wren_i | input | 1 | Write-enable command strobe |
| wrdi_i | input | 1 | Write-disable command strobe |
| wrsr_i | input | 1 | Status-write data byte received strobe |
| wrsr_data_i | input | 8 | Status-write data byte |
| sel_rise_i | input | 1 | Chip select released strobe |
| chk_addr_i | input | ADDR_W | Array address to be programmed |
| busy_i | input | 1 | Internal write cycle in progress |
| rdsr_o | output | 8 | Status byte for read-back |
| arr_wr_ok_o | output | 1 | Array write to chk_addr_i allowed |
| sts_wr_ok_o | output | 1 | Status write allowed now |
| sts_start_o | output | 1 | One-cycle pulse: status write committed, start timed cycle |

## Verification
The bench targets the boundary addresses on each side of every fence (BFFF/C000, 7FFF/8000, 0000/FFFF). A wrong decode there would let a fenced page be programmed or refuse a free one. It drops the pin low between the data byte and the chip-select release. A design that checked protection only at capture would then commit a write it should abort. It writes the status byte with the pin tied low while protect-enable is 0, which a design that honoured the pin unconditionally would refuse. It also strobes commands during busy and watches the latch clear when busy falls. A design that committed during busy, or kept the latch after the cycle, would let a second program run without a fresh enable.

// File: rtl/sr_pkg.sv
// Shared definitions for the status/protection block.
// Assumes an 8-bit status byte with fixed bit positions decoded by software.
package sr_pkg;
    localparam int STS_W      = 8;
    localparam int PEN_BIT    = 7;
    localparam int BP1_BIT    = 3;
    localparam int BP0_BIT    = 2;
    localparam int WEL_BIT    = 1;
    localparam int RDY_BIT    = 0;

    // Non-volatile part of the status byte, kept in flops here.
    typedef struct packed {
        logic       pen;
        logic [1:0] bp;
    } nv_bits_t;

    typedef enum logic [1:0] {
        FENCE_NONE    = 2'b00,
        FENCE_QUARTER = 2'b01,
        FENCE_HALF    = 2'b10,
        FENCE_ALL     = 2'b11
    } fence_e;
endpackage

// File: rtl/sr_wel_latch.sv
// Write-enable latch. Set by the enable strobe, cleared by the disable strobe,
// cleared when an internal write cycle ends (busy falls).
// Assumes enable and disable strobes are never asserted together; disable wins if they are.
module sr_wel_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic busy_i,
    input  logic wren_i,
    input  logic wrdi_i,
    output logic wel_o
);
    logic busy_q;

    // Track busy and update the latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            wel_o  <= 1'b0;
        end else begin
            busy_q <= busy_i;
            if (busy_q && !busy_i) begin
                wel_o <= 1'b0;
            end else if (!busy_i) begin
                if (wrdi_i) begin
                    wel_o <= 1'b0;
                end else if (wren_i) begin
                    wel_o <= 1'b1;
                end
            end
        end
    end

    // R6
    wel_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !busy_i) |=> !wel_o);
    // R3
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |=> $stable(wel_o));
    // R2
    wren_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wren_i && !wrdi_i && !busy_i && !busy_q) |=> wel_o);
endmodule

// File: rtl/sr_nv_regs.sv
// Protect-enable and block-protect bits with the pending status-write holder.
// A status write is captured on the data strobe and committed on chip-select release;
// hardware lock appearing in between discards it. Assumes the data strobe and the
// release strobe never fall in the same cycle.
module sr_nv_regs
    import sr_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     busy_i,
    input  logic     wel_i,
    input  logic     hw_lock_i,
    input  logic     wrsr_i,
    input  nv_bits_t wr_bits_i,
    input  logic     sel_rise_i,
    output nv_bits_t nv_o,
    output logic     start_o
);
    logic     pend_q;
    nv_bits_t pdata_q;
    logic     accept;

    // Capture condition for an incoming status byte.
    always_comb begin
        accept = wrsr_i && wel_i && !busy_i && !hw_lock_i;
    end

    // Pending holder, commit and start pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q  <= 1'b0;
            pdata_q <= '0;
            nv_o    <= '0;
            start_o <= 1'b0;
        end else begin
            start_o <= 1'b0;
            if (accept) begin
                pend_q  <= 1'b1;
                pdata_q <= wr_bits_i;
            end else if (pend_q && hw_lock_i) begin
                pend_q <= 1'b0;
            end else if (pend_q && sel_rise_i) begin
                pend_q  <= 1'b0;
                nv_o    <= pdata_q;
                start_o <= 1'b1;
            end
        end
    end

    // R9
    hw_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hw_lock_i |=> $stable(nv_o));
    // R11
    abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && hw_lock_i) |=> !start_o);
    // R8
    no_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wrsr_i && !wel_i && !pend_q) |=> (!pend_q && $stable(nv_o)));
    // R7
    start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> !start_o);
endmodule

// File: rtl/sr_range_guard.sv
// Decodes the block-protect field against the top address bits.
// Assumes the fenced regions are aligned to quarters of the address space.
module sr_range_guard
    import sr_pkg::*;
(
    input  logic [1:0] bp_i,
    input  logic [1:0] addr_top_i,
    output logic       fenced_o
);
    // Map the protect level onto the two top address bits.
    always_comb begin
        unique case (fence_e'(bp_i))
            FENCE_NONE:    fenced_o = 1'b0;
            FENCE_QUARTER: fenced_o = &addr_top_i;
            FENCE_HALF:    fenced_o = addr_top_i[1];
            default:       fenced_o = 1'b1;
        endcase
    end

    // R5
    always_comb begin
        all_fence_chk: assert (!(bp_i == 2'b11 && !fenced_o) || $isunknown(bp_i));
    end
endmodule

// File: rtl/sr_protect_ctrl.sv
// Status register and write-protection guard for a serial memory.
// Combines the enable latch, protect bits and address fence into the read-back
// byte and the two allow outputs. Assumes one-cycle command strobes from the decoder
// and a busy flag from an external write-cycle timer.
module sr_protect_ctrl
    import sr_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wp_n_i,
    input  logic              wren_i,
    input  logic              wrdi_i,
    input  logic              wrsr_i,
    input  logic [STS_W-1:0]  wrsr_data_i,
    input  logic              sel_rise_i,
    input  logic [ADDR_W-1:0] chk_addr_i,
    input  logic              busy_i,
    output logic [STS_W-1:0]  rdsr_o,
    output logic              arr_wr_ok_o,
    output logic              sts_wr_ok_o,
    output logic              sts_start_o
);
    localparam int TOP_LSB = ADDR_W - 2;

    logic     wel;
    logic     hw_lock;
    logic     fenced;
    nv_bits_t nv;
    nv_bits_t wr_bits;
    logic     unused_bits;

    // Pick the stored fields out of the incoming status byte.
    always_comb begin
        wr_bits.pen = wrsr_data_i[PEN_BIT];
        wr_bits.bp  = {wrsr_data_i[BP1_BIT], wrsr_data_i[BP0_BIT]};
        unused_bits = ^{wrsr_data_i[6:4], wrsr_data_i[WEL_BIT], wrsr_data_i[RDY_BIT],
                        chk_addr_i[TOP_LSB-1:0]};
    end

    // Hardware lock: pin low and protect-enable set.
    always_comb begin
        hw_lock = !wp_n_i && nv.pen;
    end

    sr_wel_latch u_wel (
        .clk    (clk),
        .rst_n  (rst_n),
        .busy_i (busy_i),
        .wren_i (wren_i),
        .wrdi_i (wrdi_i),
        .wel_o  (wel)
    );

    sr_nv_regs u_nv (
        .clk        (clk),
        .rst_n      (rst_n),
        .busy_i     (busy_i),
        .wel_i      (wel),
        .hw_lock_i  (hw_lock),
        .wrsr_i     (wrsr_i),
        .wr_bits_i  (wr_bits),
        .sel_rise_i (sel_rise_i),
        .nv_o       (nv),
        .start_o    (sts_start_o)
    );

    sr_range_guard u_guard (
        .bp_i       (nv.bp),
        .addr_top_i (chk_addr_i[ADDR_W-1:TOP_LSB]),
        .fenced_o   (fenced)
    );

    // Read-back byte and allow outputs.
    always_comb begin
        if (busy_i) begin
            rdsr_o = '1;
        end else begin
            rdsr_o          = '0;
            rdsr_o[PEN_BIT] = nv.pen;
            rdsr_o[BP1_BIT] = nv.bp[1];
            rdsr_o[BP0_BIT] = nv.bp[0];
            rdsr_o[WEL_BIT] = wel;
        end
        arr_wr_ok_o = wel && !busy_i && !fenced;
        sts_wr_ok_o = wel && !busy_i && !hw_lock;
    end

    // R4
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_i |-> (rdsr_o[6:4] == 3'b000 && !rdsr_o[RDY_BIT]));
    // R12
    pin_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wel && !busy_i && !fenced) |-> arr_wr_ok_o);
endmodule

// File: tb/tb_sr_protect_ctrl.sv
module tb_sr_protect_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wp_n = 1'b1, wren = 1'b0, wrdi = 1'b0, wrsr = 1'b0, sel_rise = 1'b0, busy = 1'b0;
    logic [7:0]  wdata = 8'h00;
    logic [15:0] addr = 16'h0000;
    logic [7:0]  rdsr;
    logic        arr_ok, sts_ok, start;

    int compared = 0, mismatched = 0;
    string cur_req = "R1";
    bit done = 1'b0;

    // behavioural model state
    bit m_wel, m_pen, m_pend, m_start, m_busy_q;
    bit [1:0] m_bp;
    bit [7:0] m_pdata;

    always #2.5 clk = ~clk;

    sr_protect_ctrl #(.ADDR_W(16)) dut (
        .clk(clk), .rst_n(rst_n), .wp_n_i(wp_n), .wren_i(wren), .wrdi_i(wrdi),
        .wrsr_i(wrsr), .wrsr_data_i(wdata), .sel_rise_i(sel_rise), .chk_addr_i(addr),
        .busy_i(busy), .rdsr_o(rdsr), .arr_wr_ok_o(arr_ok), .sts_wr_ok_o(sts_ok),
        .sts_start_o(start)
    );

    function automatic bit fenced(bit [1:0] bp, bit [15:0] a);
        if (bp == 2'd0) return 1'b0;
        if (bp == 2'd1) return a >= 16'hC000;
        if (bp == 2'd2) return a >= 16'h8000;
        return 1'b1;
    endfunction

    // model update at each edge
    always @(posedge clk) begin
        bit lock;
        lock = !wp_n && m_pen;
        if (!rst_n) begin
            m_wel = 0; m_pen = 0; m_bp = 0; m_pend = 0; m_start = 0; m_busy_q = 0;
        end else begin
            m_start = 0;
            if (m_busy_q && !busy) m_wel = 0;
            else if (!busy && wrdi) m_wel = 0;
            else if (!busy && wren) m_wel = 1;
            if (wrsr && !busy && m_wel_prev() && !lock) begin
                m_pend = 1; m_pdata = wdata;
            end else if (m_pend && lock) m_pend = 0;
            else if (m_pend && sel_rise) begin
                m_pend = 0; m_pen = m_pdata[7]; m_bp = m_pdata[3:2]; m_start = 1;
            end
            m_busy_q = busy;
        end
    end

    // latch value before this edge's update (captured below)
    bit wel_before;
    always @(negedge clk) wel_before = m_wel;
    function automatic bit m_wel_prev();
        return wel_before;
    endfunction

    // compare every cycle, 1 ns after the edge
    always @(posedge clk) begin
        #1;
        if (rst_n || cur_req == "R1") begin
            bit [7:0] e_rd;
            bit e_arr, e_sts;
            e_rd = busy ? 8'hFF : {m_pen, 3'b000, m_bp, m_wel, 1'b0};
            e_arr = m_wel && !busy && !fenced(m_bp, addr);
            e_sts = m_wel && !busy && !(!wp_n && m_pen);
            compared++;
            if (rdsr !== e_rd || arr_ok !== e_arr || sts_ok !== e_sts || start !== m_start) begin
                mismatched++;
                $display("FAIL %s: rdsr=%h arr=%b sts=%b start=%b expected rdsr=%h arr=%b sts=%b start=%b",
                         cur_req, rdsr, arr_ok, sts_ok, start, e_rd, e_arr, e_sts, m_start);
            end
        end
    end

    task automatic tick(int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic strobe(ref logic s);
        @(negedge clk); s = 1'b1;
        @(negedge clk); s = 1'b0;
    endtask

    task automatic status_write(bit [7:0] d);
        @(negedge clk); wdata = d; wrsr = 1'b1;
        @(negedge clk); wrsr = 1'b0;
        @(negedge clk); sel_rise = 1'b1;
        @(negedge clk); sel_rise = 1'b0;
    endtask

    task automatic run_cycle(int n);
        @(negedge clk); busy = 1'b1;
        tick(n);
        busy = 1'b0;
        tick(2);
    endtask

    task automatic sweep(bit [15:0] a0, bit [15:0] a1, bit [15:0] a2, bit [15:0] a3);
        @(negedge clk); addr = a0;
        @(negedge clk); addr = a1;
        @(negedge clk); addr = a2;
        @(negedge clk); addr = a3;
        @(negedge clk);
    endtask

    initial begin
        // R1 reset state
        cur_req = "R1";
        tick(3);
        rst_n = 1'b1;
        tick(2);
        // R2 enable then disable with pin low
        cur_req = "R2";
        strobe(wren); tick(1);
        wp_n = 1'b0;
        strobe(wrdi); tick(1);
        // R8 status write without latch
        cur_req = "R8";
        status_write(8'h8C); tick(2);
        // R10 pin low, protect-enable 0, write fence level 1
        cur_req = "R10";
        strobe(wren);
        status_write(8'h04);
        // R3 busy: all ones, strobes ignored
        cur_req = "R3";
        @(negedge clk); busy = 1'b1;
        strobe(wrdi); strobe(wren);
        @(negedge clk); wrsr = 1'b1; wdata = 8'h0C;
        @(negedge clk); wrsr = 1'b0;
        tick(3);
        // R6 latch drops after busy falls
        cur_req = "R6";
        busy = 1'b0;
        tick(3);
        // R5 fence sweeps per level
        cur_req = "R5";
        wp_n = 1'b1;
        strobe(wren);
        sweep(16'h0000, 16'hBFFF, 16'hC000, 16'hFFFF);
        cur_req = "R7";
        status_write(8'h08);
        run_cycle(4);
        cur_req = "R5";
        strobe(wren);
        sweep(16'h7FFF, 16'h8000, 16'h0001, 16'hFFFE);
        cur_req = "R7";
        status_write(8'h0C);
        run_cycle(3);
        cur_req = "R5";
        strobe(wren);
        sweep(16'h0000, 16'h4000, 16'h8000, 16'hFFFF);
        cur_req = "R7";
        status_write(8'h80);
        run_cycle(3);
        // R9 hardware lock refuses status write
        cur_req = "R9";
        wp_n = 1'b0;
        strobe(wren);
        status_write(8'h00);
        tick(2);
        // R12 pin does not touch array allow
        cur_req = "R12";
        sweep(16'h1234, 16'hC000, 16'hFFFF, 16'h0000);
        strobe(wrdi);
        // R11 abort on pin low before release
        cur_req = "R11";
        wp_n = 1'b1;
        strobe(wren);
        @(negedge clk); wdata = 8'h08; wrsr = 1'b1;
        @(negedge clk); wrsr = 1'b0; wp_n = 1'b0;
        @(negedge clk); wp_n = 1'b1;
        @(negedge clk); sel_rise = 1'b1;
        @(negedge clk); sel_rise = 1'b0;
        tick(3);
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule